// File: doc/BRIEF.md
# Memory Encryption Tweak Composer

This block sits between the load/store path of a core and a memory encryption engine. For each access it builds the 192-bit associated-data word, called the tweak, that the engine binds to the ciphertext of the line. The tweak carries several things. It records which of three address windows the access falls in, one window for each of user, supervisor and machine mode. It holds the line offset of the access inside the governing window, the privilege of the access, and the page-table permission and select bits. It ends with an 80-bit session identifier taken from per-mode session registers. Decryption succeeds only when every one of these inputs matches the values used at encryption time. Memory of different domains is therefore kept apart by cryptography and not by trusted metadata tables.

Software programs the windows and session registers through a small write port that carries the privilege of the writer. Machine mode can also program a separate override set for loads and one for stores. An override set can force any field other than the counter to a fixed value, and a zero value disables that field. The 58-bit counter field is left zero, and the engine fills it. Requests arrive on a valid/ready handshake and leave through a one-stage output register on a second valid/ready handshake.

Top module: `mem_tweak_composer`

## Requirements
- R1: The tweak is laid out as follows: counter at [191:134], line offset at [133:92], window hit bits at [91:89], privilege at [88:87], PTE field at [86:80], session identifier at [79:0]. The counter field is always zero at the output.
- R2: Window m (0 user, 1 supervisor, 2 machine) hits when its enable bit is set and ((va XOR base) AND mask) is zero. Hit bit m is placed at tweak bit 89+m.
- R3: When several windows hit, the user window takes precedence over the supervisor window, and the supervisor window takes precedence over the machine window. The winner supplies both the offset base and the session register pair.
- R4: The offset field is (va − base of the winner) modulo 2^48, shifted right by 6. It is zero when no window hits.
- R5: The privilege field is the raw 2-bit request privilege (00 user, 01 supervisor, 11 machine). The PTE field is {sel[1:0], U, G, R, W, X}, with sel at [86:85] and X at [80].
- R6: The session field depends on sel. 00 gives zero, 01 gives register 0 of the chosen mode, 10 gives register 1, and 11 gives register 0 XOR register 1. The chosen mode is the winning window. With no hit it is the request's own level, where 11 is machine, 01 is supervisor and any other value is user.
- R7: Two override sets exist, set 0 for loads and set 1 for stores. Each set has an enable word at address 15+4d and values at 16+4d (offset), 17+4d (12-bit {hits, priv, PTE}) and 18+4d (session). Enable bit 0 replaces the offset, bit 1 the hits, bit 2 the privilege, bit 3 the PTE field and bit 4 the session. A set acts only on requests of its own direction.
- R8: The configuration map is: base of window m at address m, mask at 3+m, enable (bit 0) at 6+m, session register k of mode m at 9+2m+k. A writer's level (as in R6) must be at least the mode owning the register, and override registers need machine level. A denied write changes nothing and sets cfg_illegal for exactly the next cycle. Addresses above 22 are ignored without the flag.
- R9: An accepted request appears on tw_valid one cycle later. While tw_valid is high and tw_ready is low, the output holds steady and req_ready is low.
- R10: After reset, tw_valid, cfg_illegal and all configuration registers are zero and req_ready is high.

Top module ports (in list order):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | SID_W | Write data, low bits used for narrower registers |
| cfg_priv | input | 2 | Privilege of the writer |
| cfg_illegal | output | 1 | Pulses one cycle after a denied write |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | VA_W | Virtual address of the access |
| req_priv | input | 2 | Privilege of the access |
| req_store | input | 1 | 1 for store, 0 for load |
| req_perm | input | 5 | PTE bits {U,G,R,W,X} |
| req_sel | input | 2 | PTE tweak-select bits |
| tw_valid | output | 1 | Tweak valid towards the engine |
| tw_ready | input | 1 | Engine accepts the tweak |
| tw_store | output | 1 | Direction of the tweak's access |
| tw_data | output | TW_W | Composed tweak |

## Verification
The properties assume that the engine drives tw_ready as a plain level and that requesters keep their fields stable only as far as the handshake needs. They also assume that privilege code 10 is never used for a request whose check depends on it. The bench never issues that code. It programs the windows so that they overlap, nest and leave a gap, and sweeps every enable combination, every select code and every legal privilege over addresses chosen inside, at the edge of and outside each window. Bases with unmasked low bits make the offset subtraction wrap and borrow. Override and permission cases are driven from each writer level, and each denied write is followed by a request that would reveal any change.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int N_MODE  = 3;
  localparam int N_FIELD = 5;
  localparam int META_W  = 12;

  // field enable bit positions in an override set
  localparam int F_OFF = 0;
  localparam int F_MAP = 1;
  localparam int F_PRV = 2;
  localparam int F_PTE = 3;
  localparam int F_SID = 4;

  // configuration address bases
  localparam int A_BASE = 0;
  localparam int A_MASK = 3;
  localparam int A_EN   = 6;
  localparam int A_SID  = 9;
  localparam int A_OVR  = 15;
  localparam int A_LAST = 22;

  typedef enum logic [1:0] {
    PRIV_USR = 2'b00,
    PRIV_SUP = 2'b01,
    PRIV_MAC = 2'b11
  } priv_e;

  function automatic logic [1:0] level_of(input logic [1:0] p);
    if (p == PRIV_MAC)      return 2'd2;
    else if (p == PRIV_SUP) return 2'd1;
    else                    return 2'd0;
  endfunction
endpackage

// File: rtl/tw_cfg_regs.sv
module tw_cfg_regs
  import tw_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int OFF_W = 42,
  parameter int SID_W = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [4:0]       addr,
  input  logic [SID_W-1:0] wdata,
  input  logic [1:0]       priv,
  output logic             illegal,
  output logic [VA_W-1:0]  base_o  [N_MODE],
  output logic [VA_W-1:0]  mask_o  [N_MODE],
  output logic             en_o    [N_MODE],
  output logic [SID_W-1:0] sid_o   [2*N_MODE],
  output logic [N_FIELD-1:0] oen_o [2],
  output logic [OFF_W-1:0] ooff_o  [2],
  output logic [META_W-1:0] ometa_o [2],
  output logic [SID_W-1:0] osid_o  [2]
);
  logic [1:0] tgt;
  logic [1:0] lvl;
  logic       mapped;
  logic       wr_ok;
  logic       deny;

  always_comb begin
    tgt    = 2'd2;
    mapped = 1'b1;
    if (addr < 5'(A_SID))        tgt = 2'(addr % 5'd3);
    else if (addr < 5'(A_OVR))   tgt = 2'((addr - 5'(A_SID)) >> 1);
    else if (addr > 5'(A_LAST))  mapped = 1'b0;
    lvl   = level_of(priv);
    wr_ok = we && mapped && (lvl >= tgt);
    deny  = we && mapped && (lvl <  tgt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal <= 1'b0;
      for (int m = 0; m < N_MODE; m++) begin
        base_o[m] <= '0;
        mask_o[m] <= '0;
        en_o[m]   <= 1'b0;
      end
      for (int k = 0; k < 2*N_MODE; k++) sid_o[k] <= '0;
      for (int d = 0; d < 2; d++) begin
        oen_o[d]   <= '0;
        ooff_o[d]  <= '0;
        ometa_o[d] <= '0;
        osid_o[d]  <= '0;
      end
    end else begin
      illegal <= deny;
      if (wr_ok) begin
        for (int m = 0; m < N_MODE; m++) begin
          if (addr == 5'(A_BASE + m)) base_o[m] <= wdata[VA_W-1:0];
          if (addr == 5'(A_MASK + m)) mask_o[m] <= wdata[VA_W-1:0];
          if (addr == 5'(A_EN + m))   en_o[m]   <= wdata[0];
        end
        for (int k = 0; k < 2*N_MODE; k++)
          if (addr == 5'(A_SID + k)) sid_o[k] <= wdata;
        for (int d = 0; d < 2; d++) begin
          if (addr == 5'(A_OVR + 4*d))     oen_o[d]   <= wdata[N_FIELD-1:0];
          if (addr == 5'(A_OVR + 4*d + 1)) ooff_o[d]  <= wdata[OFF_W-1:0];
          if (addr == 5'(A_OVR + 4*d + 2)) ometa_o[d] <= wdata[META_W-1:0];
          if (addr == 5'(A_OVR + 4*d + 3)) osid_o[d]  <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/tw_range_match.sv
module tw_range_match
  import tw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int LINE_W = 6,
  localparam int OFF_W = VA_W - LINE_W
) (
  input  logic [VA_W-1:0]  va,
  input  logic [VA_W-1:0]  base [N_MODE],
  input  logic [VA_W-1:0]  mask [N_MODE],
  input  logic             en   [N_MODE],
  output logic [N_MODE-1:0] hit,
  output logic             win_valid,
  output logic [1:0]       win_idx,
  output logic [OFF_W-1:0] offset
);
  for (genvar m = 0; m < N_MODE; m++) begin : g_cmp
    assign hit[m] = en[m] && (((va ^ base[m]) & mask[m]) == '0);
  end

  // lowest index has precedence: scan from the top down
  always_comb begin
    win_valid = 1'b0;
    win_idx   = 2'd0;
    for (int m = N_MODE - 1; m >= 0; m--) begin
      if (hit[m]) begin
        win_valid = 1'b1;
        win_idx   = 2'(m);
      end
    end
  end

  logic [VA_W-1:0] wb;
  logic            borrow;

  always_comb begin
    wb     = win_valid ? base[win_idx] : '0;
    borrow = va[LINE_W-1:0] < wb[LINE_W-1:0];
    offset = win_valid
           ? (va[VA_W-1:LINE_W] - wb[VA_W-1:LINE_W] - OFF_W'(borrow))
           : '0;
  end
endmodule

// File: rtl/tw_session_sel.sv
module tw_session_sel
  import tw_pkg::*;
#(
  parameter int SID_W = 80
) (
  input  logic [SID_W-1:0] sid  [2*N_MODE],
  input  logic [1:0]       mode,
  input  logic [1:0]       sel,
  output logic [SID_W-1:0] sid_out
);
  logic [SID_W-1:0] r0;
  logic [SID_W-1:0] r1;

  always_comb begin
    r0 = sid[{mode, 1'b0}];
    r1 = sid[{mode, 1'b1}];
    unique case (sel)
      2'b00:   sid_out = '0;
      2'b01:   sid_out = r0;
      2'b10:   sid_out = r1;
      default: sid_out = r0 ^ r1;
    endcase
  end
endmodule

// File: rtl/mem_tweak_composer.sv
module mem_tweak_composer
  import tw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int LINE_W = 6,
  parameter int CTR_W  = 58,
  parameter int SID_W  = 80,
  localparam int OFF_W = VA_W - LINE_W,
  localparam int TW_W  = CTR_W + OFF_W + META_W + SID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_addr,
  input  logic [SID_W-1:0] cfg_wdata,
  input  logic [1:0]       cfg_priv,
  output logic             cfg_illegal,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_priv,
  input  logic             req_store,
  input  logic [4:0]       req_perm,
  input  logic [1:0]       req_sel,
  output logic             tw_valid,
  input  logic             tw_ready,
  output logic             tw_store,
  output logic [TW_W-1:0]  tw_data
);
  logic [VA_W-1:0]    base [N_MODE];
  logic [VA_W-1:0]    mask [N_MODE];
  logic               en   [N_MODE];
  logic [SID_W-1:0]   sid  [2*N_MODE];
  logic [N_FIELD-1:0] ovr_en   [2];
  logic [OFF_W-1:0]   ovr_off  [2];
  logic [META_W-1:0]  ovr_meta [2];
  logic [SID_W-1:0]   ovr_sid  [2];

  tw_cfg_regs #(.VA_W(VA_W), .OFF_W(OFF_W), .SID_W(SID_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .priv(cfg_priv), .illegal(cfg_illegal), .base_o(base), .mask_o(mask),
    .en_o(en), .sid_o(sid), .oen_o(ovr_en), .ooff_o(ovr_off),
    .ometa_o(ovr_meta), .osid_o(ovr_sid)
  );

  logic [N_MODE-1:0] hit;
  logic              win_valid;
  logic [1:0]        win_idx;
  logic [OFF_W-1:0]  off_raw;

  tw_range_match #(.VA_W(VA_W), .LINE_W(LINE_W)) u_match (
    .va(req_va), .base(base), .mask(mask), .en(en), .hit(hit),
    .win_valid(win_valid), .win_idx(win_idx), .offset(off_raw)
  );

  logic [1:0]       sid_mode;
  logic [SID_W-1:0] sid_raw;

  assign sid_mode = win_valid ? win_idx : level_of(req_priv);

  tw_session_sel #(.SID_W(SID_W)) u_sess (
    .sid(sid), .mode(sid_mode), .sel(req_sel), .sid_out(sid_raw)
  );

  // apply the override set of this request's direction
  logic [N_FIELD-1:0] oe;
  logic [META_W-1:0]  om;
  logic [OFF_W-1:0]   f_off;
  logic [2:0]         f_map;
  logic [1:0]         f_prv;
  logic [6:0]         f_pte;
  logic [SID_W-1:0]   f_sid;

  always_comb begin
    oe    = ovr_en[req_store];
    om    = ovr_meta[req_store];
    f_off = oe[F_OFF] ? ovr_off[req_store] : off_raw;
    f_map = oe[F_MAP] ? om[11:9] : hit;
    f_prv = oe[F_PRV] ? om[8:7]  : req_priv;
    f_pte = oe[F_PTE] ? om[6:0]  : {req_sel, req_perm};
    f_sid = oe[F_SID] ? ovr_sid[req_store] : sid_raw;
  end

  assign req_ready = !tw_valid || tw_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_valid <= 1'b0;
      tw_store <= 1'b0;
      tw_data  <= '0;
    end else if (req_ready) begin
      tw_valid <= req_valid;
      if (req_valid) begin
        tw_store <= req_store;
        tw_data  <= {{CTR_W{1'b0}}, f_off, f_map, f_prv, f_pte, f_sid};
      end
    end
  end
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int TW_W  = 192,
  parameter int CTR_W = 58,
  parameter int SID_W = 80
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [4:0]      cfg_addr,
  input logic [1:0]      cfg_priv,
  input logic            cfg_illegal,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_priv,
  input logic            req_store,
  input logic [4:0]      req_perm,
  input logic [1:0]      req_sel,
  input logic            tw_valid,
  input logic            tw_ready,
  input logic            tw_store,
  input logic [TW_W-1:0] tw_data,
  input logic [4:0]      ld_en,
  input logic [4:0]      st_en
);
  localparam int PTE_LO = SID_W;
  localparam int PRV_LO = SID_W + 7;

  logic [4:0] cur_en;
  assign cur_en = req_store ? st_en : ld_en;

  // R1
  ctr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tw_valid |-> (tw_data[TW_W-1 -: CTR_W] == '0));

  // R5
  priv_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cur_en[2]) |=> (tw_data[PRV_LO +: 2] == $past(req_priv)));

  // R5
  pte_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cur_en[3])
      |=> (tw_data[PTE_LO +: 7] == {$past(req_sel), $past(req_perm)}));

  // R8
  deny_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_priv != 2'b11 && cfg_addr >= 5'd15 && cfg_addr <= 5'd22) |=> cfg_illegal);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && !tw_ready) |=> (tw_valid && $stable(tw_data) && $stable(tw_store)));

  // R9
  ready_block_chk: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && !tw_ready) |-> !req_ready);

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (tw_valid && tw_store == $past(req_store)));

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!tw_valid && !cfg_illegal));
endmodule

bind mem_tweak_composer tw_checker #(.TW_W(TW_W), .CTR_W(CTR_W), .SID_W(SID_W)) u_tw_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_priv(cfg_priv),
  .cfg_illegal(cfg_illegal), .req_valid(req_valid), .req_ready(req_ready),
  .req_priv(req_priv), .req_store(req_store), .req_perm(req_perm), .req_sel(req_sel),
  .tw_valid(tw_valid), .tw_ready(tw_ready), .tw_store(tw_store), .tw_data(tw_data),
  .ld_en(ovr_en[0]), .st_en(ovr_en[1])
);

// File: tb/test_mem_tweak_composer.sv
module test_mem_tweak_composer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [79:0] cfg_wdata = '0;
  logic [1:0]  cfg_priv = '0;
  logic        cfg_illegal;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [1:0]  req_priv = '0;
  logic        req_store = 1'b0;
  logic [4:0]  req_perm = '0;
  logic [1:0]  req_sel = '0;
  logic        tw_valid;
  logic        tw_ready = 1'b1;
  logic        tw_store;
  logic [191:0] tw_data;

  mem_tweak_composer i_mem_tweak_composer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_priv(cfg_priv), .cfg_illegal(cfg_illegal), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .req_priv(req_priv), .req_store(req_store),
    .req_perm(req_perm), .req_sel(req_sel), .tw_valid(tw_valid), .tw_ready(tw_ready),
    .tw_store(tw_store), .tw_data(tw_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side copy of what was written, following R7/R8
  logic [47:0] m_base [3];
  logic [47:0] m_mask [3];
  logic        m_en   [3];
  logic [79:0] m_sid  [6];
  logic [4:0]  o_en   [2];
  logic [41:0] o_off  [2];
  logic [11:0] o_meta [2];
  logic [79:0] o_sid  [2];

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] p);
    return (p == 2'b11) ? 2 : (p == 2'b01) ? 1 : 0;
  endfunction

  function automatic logic [191:0] model(input logic [47:0] va, input logic [1:0] p,
                                         input logic st, input logic [4:0] perm, input logic [1:0] sel);
    logic [2:0]  hit;
    int          win;
    int          d;
    logic [47:0] diff;
    logic [41:0] off;
    logic [79:0] s;
    logic [2:0]  mp;
    logic [1:0]  pv;
    logic [6:0]  pt;
    for (int m = 0; m < 3; m++) hit[m] = m_en[m] && (((va ^ m_base[m]) & m_mask[m]) == 0);
    win = -1;
    for (int m = 2; m >= 0; m--) if (hit[m]) win = m;
    if (win >= 0) begin
      diff = va - m_base[win];
      off  = diff[47:6];
    end else off = '0;
    d = (win >= 0) ? win : lvl(p);
    case (sel)
      2'b00: s = '0;
      2'b01: s = m_sid[2*d];
      2'b10: s = m_sid[2*d+1];
      default: s = m_sid[2*d] ^ m_sid[2*d+1];
    endcase
    mp = hit; pv = p; pt = {sel, perm};
    if (o_en[st][0]) off = o_off[st];
    if (o_en[st][1]) mp = o_meta[st][11:9];
    if (o_en[st][2]) pv = o_meta[st][8:7];
    if (o_en[st][3]) pt = o_meta[st][6:0];
    if (o_en[st][4]) s  = o_sid[st];
    return {58'd0, off, mp, pv, pt, s};
  endfunction

  task automatic cfg_wr(input logic [4:0] a, input logic [79:0] dat, input logic [1:0] p);
    int  tgt;
    bit  mapped;
    bit  ok;
    tgt = 2; mapped = 1'b1;
    if (a < 9) tgt = a % 3;
    else if (a < 15) tgt = (a - 9) / 2;
    else if (a > 22) mapped = 1'b0;
    ok = mapped && (lvl(p) >= tgt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = dat; cfg_priv = p;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ok) begin
      if (a < 3) m_base[a] = dat[47:0];
      else if (a < 6) m_mask[a-3] = dat[47:0];
      else if (a < 9) m_en[a-6] = dat[0];
      else if (a < 15) m_sid[a-9] = dat;
      else begin
        case ((a - 15) % 4)
          0: o_en[(a-15)/4]   = dat[4:0];
          1: o_off[(a-15)/4]  = dat[41:0];
          2: o_meta[(a-15)/4] = dat[11:0];
          default: o_sid[(a-15)/4] = dat;
        endcase
      end
    end
    // R8: flag high exactly for denied mapped writes
    chk(cfg_illegal == (mapped && !ok), "R8 illegal flag", 192'(cfg_illegal), 192'(mapped && !ok));
  endtask

  task automatic do_req(input logic [47:0] va, input logic [1:0] p, input logic st,
                        input logic [4:0] perm, input logic [1:0] sel);
    logic [191:0] e;
    e = model(va, p, st, perm, sel);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_priv = p; req_store = st; req_perm = perm; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tw_valid && tw_store == st, "R9 one-cycle latency", 192'({tw_valid, tw_store}), 192'({1'b1, st}));
    chk(tw_data[191:134] == 0, "R1 counter zero", tw_data, e);
    chk(tw_data[91:89] == e[91:89], "R2 hit bits", 192'(tw_data[91:89]), 192'(e[91:89]));
    chk(tw_data[133:92] == e[133:92], "R3 R4 offset from winner", 192'(tw_data[133:92]), 192'(e[133:92]));
    chk(tw_data[88:80] == e[88:80], "R5 priv and PTE", 192'(tw_data[88:80]), 192'(e[88:80]));
    chk(tw_data[79:0] == e[79:0], "R6 session", 192'(tw_data[79:0]), 192'(e[79:0]));
  endtask

  logic [47:0] addrs [6];
  logic [1:0]  privs [3];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [191:0] ea;
    logic [191:0] eb;
    for (int m = 0; m < 3; m++) begin m_base[m] = '0; m_mask[m] = '0; m_en[m] = 1'b0; end
    for (int k = 0; k < 6; k++) m_sid[k] = '0;
    for (int d = 0; d < 2; d++) begin o_en[d] = '0; o_off[d] = '0; o_meta[d] = '0; o_sid[d] = '0; end
    addrs[0] = 48'h0000_4000_0040; addrs[1] = 48'h0000_0123_4567; addrs[2] = 48'h0010_0000_0000;
    addrs[3] = 48'h8000_0000_1000; addrs[4] = 48'h0000_7FFF_FFC0; addrs[5] = 48'h0000_0000_0800;
    privs[0] = 2'b00; privs[1] = 2'b01; privs[2] = 2'b11;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state at the ports
    chk(!tw_valid && req_ready && !cfg_illegal, "R10 reset state",
        192'({tw_valid, req_ready, cfg_illegal}), 192'(3'b010));
    do_req(48'h0000_4000_0040, 2'b11, 1'b0, 5'h1F, 2'b11);   // R10: zeroed registers give a zero tweak apart from PTE/priv

    // windows: user nested in supervisor nested in machine; bases with low bits set
    cfg_wr(5'd0, 80'h0000_4000_0000, 2'b11);
    cfg_wr(5'd3, 80'hFFFF_C000_0000, 2'b11);
    cfg_wr(5'd1, 80'h0000_0000_1010, 2'b11);
    cfg_wr(5'd4, 80'hFF80_0000_0000, 2'b11);
    cfg_wr(5'd2, 80'h0000_0000_0025, 2'b11);
    cfg_wr(5'd5, 80'h8000_0000_0000, 2'b11);
    for (int k = 0; k < 6; k++)
      cfg_wr(5'(9 + k), {16'h5A00 + 16'(k), 64'h0123_4567_89AB_CDEF ^ (64'(k) << 40)}, 2'b11);

    // sweep every enable combination, address, privilege and select (R2, R3, R4, R6)
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 3; m++) cfg_wr(5'(6 + m), 80'(c >> m), 2'b11);
      for (int a = 0; a < 6; a++)
        for (int p = 0; p < 3; p++)
          for (int s = 0; s < 4; s++)
            do_req(addrs[a], privs[p], 1'(a + s), 5'(c * 7 + a * 3 + s), 2'(s));
    end

    // R8: user may not write supervisor window, supervisor may write user window
    cfg_wr(5'd4, 80'h0, 2'b00);
    do_req(48'h0000_0123_4567, 2'b01, 1'b0, 5'h05, 2'b01);
    cfg_wr(5'd9, 80'hFEED_0000_0000_0000_0001, 2'b01);
    cfg_wr(5'd14, 80'h1, 2'b01);
    do_req(48'h0000_4000_0080, 2'b00, 1'b1, 5'h0A, 2'b01);
    do_req(48'h8000_0000_0000, 2'b11, 1'b0, 5'h0A, 2'b11);
    cfg_wr(5'd25, 80'h7, 2'b00);   // unmapped: ignored, no flag

    // R7: override writes from below machine are refused
    cfg_wr(5'd15, 80'h1F, 2'b01);
    cfg_wr(5'd18, 80'h1, 2'b00);
    do_req(48'h0000_4000_0040, 2'b00, 1'b0, 5'h11, 2'b10);

    // R7: load set replaces the session only; store side untouched
    cfg_wr(5'd18, 80'hAAAA_BBBB_CCCC_DDDD_EEEE, 2'b11);
    cfg_wr(5'd15, 80'h10, 2'b11);
    do_req(48'h0000_4000_0040, 2'b00, 1'b0, 5'h11, 2'b10);
    do_req(48'h0000_4000_0040, 2'b00, 1'b1, 5'h11, 2'b10);

    // R7: store set replaces every field, zero values disable hits and PTE
    cfg_wr(5'd20, 80'h3_FFFF_0000_1234, 2'b11);
    cfg_wr(5'd21, 80'h180, 2'b11);
    cfg_wr(5'd22, 80'h0, 2'b11);
    cfg_wr(5'd19, 80'h1F, 2'b11);
    for (int p = 0; p < 3; p++) begin
      do_req(addrs[p], privs[p], 1'b1, 5'h1F, 2'b11);
      do_req(addrs[p], privs[p], 1'b0, 5'h1F, 2'b11);
    end
    cfg_wr(5'd15, 80'h0, 2'b11);
    cfg_wr(5'd19, 80'h0, 2'b11);

    // R9: stall holds output and blocks the next request
    ea = model(48'h0000_4000_1000, 2'b00, 1'b0, 5'h03, 2'b01);
    eb = model(48'h0000_0000_2000, 2'b01, 1'b1, 5'h0C, 2'b10);
    tw_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_va = 48'h0000_4000_1000; req_priv = 2'b00; req_store = 1'b0;
    req_perm = 5'h03; req_sel = 2'b01;
    @(negedge clk);
    req_va = 48'h0000_0000_2000; req_priv = 2'b01; req_store = 1'b1; req_perm = 5'h0C; req_sel = 2'b10;
    chk(tw_valid && !req_ready, "R9 ready low under stall", 192'({tw_valid, req_ready}), 192'(2'b10));
    @(negedge clk);
    chk(tw_valid && tw_data == ea && !tw_store, "R9 output held", tw_data, ea);
    tw_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tw_valid && tw_data == eb && tw_store, "R9 next after release", tw_data, eb);
    @(negedge clk);
    chk(!tw_valid && req_ready, "R9 drained", 192'({tw_valid, req_ready}), 192'(2'b01));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule